// File: doc/BRIEF.md
# Paged Open-Drain GPIO Bank

A byte-wide register block that controls 48 open-drain I/O lines organised as six ports of eight. Each line has an output latch that, when set, pulls the pin low. When the latch is clear the pin is released so an external source can drive it. Port reads return the synchronized pin level, inverted, so a 1 reads back for a pin that is low.

A single control byte holds one lock bit per port and a 2-bit page number. A port whose lock bit is set keeps its output state, and data writes to that port are dropped. The three offsets that follow the control byte form a window. The current page routes an access in that window to one of three register groups in an external interrupt unit: polarity, enable or interrupt ID. The block forwards strobes, index, page and write data to that unit and returns its read data. The unit's pending summary reads back at a fixed read-only offset.

Pin inputs pass through a two-flop synchronizer. The same synchronized vector goes both to the readback path and to the interrupt unit.

Top module: `pgpio_bank`

## Requirements
- R1: After reset every output latch is 0 (all pins released), every lock bit is 0 and the page is 0, so offset 0x7 reads 0x00.
- R2: A write to offset p (0x0..0x5) while lock bit p is 0 loads the byte into port p. Bit n of the byte drives `drive_low_o[8*p+n]` (1 = pull low) from the next clock edge.
- R3: A write to offset p while lock bit p is 1 leaves `drive_low_o[8*p+7:8*p]` unchanged.
- R4: A read of offset p (0x0..0x5) returns the bitwise inverse of byte p of the synchronized pin vector.
- R5: A write to offset 0x7 stores bits 5:0 as the lock bits of ports 5..0 and bits 7:6 as the page. A read of 0x7 returns the same layout, so writing 0x80 selects page 2 and 0xC0 selects page 3, both with every port unlocked.
- R6: With page 1, 2 or 3 selected, an access to offset 0x8..0xA raises `win_we_o` / `win_re_o` in the same cycle as `we_i` / `re_i`. It presents `win_page_o` = page, `win_idx_o` = offset minus 8 and `win_wdata_o` = write data, and the read returns `win_rdata_i`.
- R7: With page 0 selected, offsets 0x8..0xA read 0x00 and raise neither window strobe.
- R8: Offset 0x6 reads `irq_pend_i`. A write to 0x6 changes no port latch, lock bit or page.
- R9: Offsets 0xB..0xF read 0x00. A write to them changes no port latch, lock bit or page.
- R10: `pin_sync_o` equals `pin_i` as sampled two clock edges earlier. The read path sees the same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe, forwarded to window |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pin_i | input | 48 | Sampled pin levels |
| drive_low_o | output | 48 | Per-line pull-low enable |
| pin_sync_o | output | 48 | Synchronized pins to the interrupt unit |
| irq_pend_i | input | 8 | Pending summary from the interrupt unit |
| win_we_o | output | 1 | Window write strobe |
| win_re_o | output | 1 | Window read strobe |
| win_page_o | output | 2 | Page routing the window access |
| win_idx_o | output | 2 | Register index inside the window |
| win_wdata_o | output | 8 | Window write data |
| win_rdata_i | input | 8 | Window read data from the interrupt unit |

## Verification
The bench builds the block with its default parameters: six ports of eight lines, a three-register window and two synchronizer stages. With these values all six lock bits and the page field share the control byte. The pending and control offsets sit at 0x6 and 0x7, and offsets 0xB..0xF lie outside every decoded range. The bench can therefore reach the unmapped reads, locked and unlocked writes to every port, and every page routing of the window.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;
  typedef enum logic [2:0] {
    SEL_PORT,
    SEL_PEND,
    SEL_CTRL,
    SEL_WIN,
    SEL_NONE
  } sel_e;
endpackage

// File: rtl/pgpio_decode.sv
module pgpio_decode
  import pgpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned WIN_REGS  = 3,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              kind_o,
  output logic [ADDR_W-1:0] idx_o
);
  localparam logic [ADDR_W-1:0] PEND_OFF = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(NUM_PORTS + 1);
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(NUM_PORTS + 2);
  localparam logic [ADDR_W-1:0] WIN_END  = ADDR_W'(NUM_PORTS + 2 + WIN_REGS);

  always_comb begin
    kind_o = SEL_NONE;
    idx_o  = '0;
    if (addr_i < PEND_OFF) begin
      kind_o = SEL_PORT;
      idx_o  = addr_i;
    end else if (addr_i == PEND_OFF) begin
      kind_o = SEL_PEND;
    end else if (addr_i == CTRL_OFF) begin
      kind_o = SEL_CTRL;
    end else if (addr_i >= WIN_BASE && addr_i < WIN_END) begin
      kind_o = SEL_WIN;
      idx_o  = addr_i - WIN_BASE;
    end
  end
endmodule

// File: rtl/pgpio_sync.sv
module pgpio_sync #(
  parameter int unsigned W      = 48,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pgpio_port.sv
module pgpio_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         lock_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] drive_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              drive_o <= '0;
    else if (wr_i && !lock_i) drive_o <= wdata_i;
  end
endmodule

// File: rtl/pgpio_bank.sv
module pgpio_bank
  import pgpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 6,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned WIN_REGS    = 3,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [PORT_W-1:0]             wdata_i,
  input  logic                          we_i,
  input  logic                          re_i,
  output logic [PORT_W-1:0]             rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_i,
  output logic [NUM_PORTS*PORT_W-1:0]   drive_low_o,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_sync_o,
  input  logic [PORT_W-1:0]             irq_pend_i,
  output logic                          win_we_o,
  output logic                          win_re_o,
  output logic [1:0]                    win_page_o,
  output logic [$clog2(WIN_REGS)-1:0]   win_idx_o,
  output logic [PORT_W-1:0]             win_wdata_o,
  input  logic [PORT_W-1:0]             win_rdata_i
);
  localparam int unsigned LINES  = NUM_PORTS * PORT_W;
  localparam int unsigned IDX_W  = $clog2(WIN_REGS);
  localparam int unsigned PIDX_W = $clog2(NUM_PORTS);

  sel_e                kind;
  logic [ADDR_W-1:0]   idx;
  logic [NUM_PORTS-1:0] lock_q;
  logic [1:0]          page_q;
  logic [PORT_W-1:0]   rd_port [NUM_PORTS];
  logic [PORT_W-1:0]   ctrl_rd;
  logic                win_act;

  pgpio_decode #(
    .NUM_PORTS(NUM_PORTS), .WIN_REGS(WIN_REGS), .ADDR_W(ADDR_W)
  ) u_decode (
    .addr_i(addr_i), .kind_o(kind), .idx_o(idx)
  );

  pgpio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_sync_o)
  );

  // control byte: locks in low bits, page in top two bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      page_q <= '0;
    end else if (we_i && kind == SEL_CTRL) begin
      lock_q <= wdata_i[NUM_PORTS-1:0];
      page_q <= wdata_i[PORT_W-1:PORT_W-2];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pgpio_port #(.W(PORT_W)) u_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i && kind == SEL_PORT && idx == ADDR_W'(p)),
      .lock_i (lock_q[p]),
      .wdata_i(wdata_i),
      .drive_o(drive_low_o[p*PORT_W +: PORT_W])
    );
    assign rd_port[p] = ~pin_sync_o[p*PORT_W +: PORT_W];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[NUM_PORTS-1:0] = lock_q;
    ctrl_rd[PORT_W-1:PORT_W-2] = page_q;
  end

  assign win_act     = (kind == SEL_WIN) && (page_q != 2'd0);
  assign win_we_o    = we_i && win_act;
  assign win_re_o    = re_i && win_act;
  assign win_page_o  = page_q;
  assign win_idx_o   = IDX_W'(idx);
  assign win_wdata_o = wdata_i;

  always_comb begin
    unique case (kind)
      SEL_PORT: rdata_o = rd_port[PIDX_W'(idx)];
      SEL_PEND: rdata_o = irq_pend_i;
      SEL_CTRL: rdata_o = ctrl_rd;
      SEL_WIN:  rdata_o = win_act ? win_rdata_i : '0;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pgpio_bank_chk.sv
module pgpio_bank_chk #(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned WIN_REGS  = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [PORT_W-1:0]           wdata_i,
  input logic                        we_i,
  input logic [PORT_W-1:0]           rdata_o,
  input logic [NUM_PORTS*PORT_W-1:0] pin_i,
  input logic [NUM_PORTS*PORT_W-1:0] pin_sync_o,
  input logic [NUM_PORTS*PORT_W-1:0] drive_low_o,
  input logic [PORT_W-1:0]           irq_pend_i,
  input logic                        win_we_o,
  input logic                        win_re_o,
  input logic [NUM_PORTS-1:0]        lock_q,
  input logic [1:0]                  page_q
);
  localparam logic [ADDR_W-1:0] PEND_OFF = ADDR_W'(NUM_PORTS);
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(NUM_PORTS + 1);
  localparam logic [ADDR_W-1:0] TOP_OFF  = ADDR_W'(NUM_PORTS + 2 + WIN_REGS);

  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_PORT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(p) && !lock_q[p]) |=>
        drive_low_o[p*PORT_W +: PORT_W] == $past(wdata_i)); // R2
    AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(p) && lock_q[p]) |=>
        $stable(drive_low_o[p*PORT_W +: PORT_W])); // R3
  end

  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CTRL_OFF) |=> page_q == $past(wdata_i[PORT_W-1:PORT_W-2])); // R5
  AST_PAGE0_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_q == 2'd0) |-> (!win_we_o && !win_re_o)); // R7
  AST_PEND_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == PEND_OFF) |-> rdata_o == irq_pend_i); // R8
  AST_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= TOP_OFF) |-> rdata_o == '0); // R9
  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> pin_sync_o == $past(pin_i, 2)); // R10
endmodule

bind pgpio_bank pgpio_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .WIN_REGS(WIN_REGS)
) u_chk (.*);

// File: tb/pgpio_bank_bench.sv
`timescale 1ns/1ps
module pgpio_bank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [47:0] pin_i = '0;
  logic [47:0] drive_low_o;
  logic [47:0] pin_sync_o;
  logic [7:0]  irq_pend_i = '0;
  logic        win_we_o, win_re_o;
  logic [1:0]  win_page_o, win_idx_o;
  logic [7:0]  win_wdata_o;
  logic [7:0]  win_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  pgpio_bank u_pgpio_bank (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [47:0] m_drv = '0;
  logic [5:0]  m_lock = '0;
  logic [1:0]  m_page = '0;
  logic [47:0] hist[$];
  bit          last_locked = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [47:0] exp_sync();
    return (hist.size() == 2) ? hist[0] : 48'h0;
  endfunction

  // one bus cycle: apply inputs at negedge, compare, then advance model at posedge
  task automatic cyc(input bit we, input bit re, input logic [3:0] a, input logic [7:0] d,
                     input logic [47:0] pin, input logic [7:0] pend, input logic [7:0] wrd);
    logic [7:0] exp_rd;
    string      rtag;
    bit         wact;
    int         ai;
    we_i = we; re_i = re; addr_i = a; wdata_i = d; pin_i = pin;
    irq_pend_i = pend; win_rdata_i = wrd;
    #1;
    ai = int'(a);
    chk(last_locked ? "R3 locked port held" : "R2 drive latch", drive_low_o, m_drv);
    chk("R10 pin sync", pin_sync_o, exp_sync());
    wact = (ai >= 8 && ai <= 10 && m_page != 0);
    if (ai < 6) begin exp_rd = ~exp_sync()[ai*8 +: 8]; rtag = "R4 port readback"; end
    else if (ai == 6) begin exp_rd = pend; rtag = "R8 pending read"; end
    else if (ai == 7) begin exp_rd = {m_page, m_lock}; rtag = "R5 control read"; end
    else if (ai <= 10) begin
      exp_rd = wact ? wrd : 8'h00;
      rtag = wact ? "R6 window read" : "R7 page0 window read";
    end else begin exp_rd = 8'h00; rtag = "R9 unmapped read"; end
    chk(rtag, rdata_o, exp_rd);
    chk(wact ? "R6 window strobes" : "R7 window quiet", {win_we_o, win_re_o},
        {we && wact, re && wact});
    if (wact) begin
      chk("R6 window route", {win_page_o, win_idx_o, win_wdata_o},
          {m_page, 2'(ai - 8), d});
    end
    @(posedge clk_i);
    last_locked = 0;
    if (we) begin
      if (ai < 6) begin
        if (!m_lock[ai]) m_drv[ai*8 +: 8] = d;
        else last_locked = 1;
      end else if (ai == 7) begin
        m_lock = d[5:0];
        m_page = d[7:6];
      end
    end
    hist.push_back(pin);
    if (hist.size() > 2) void'(hist.pop_front());
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [47:0] pv;
    @(negedge clk_i);
    addr_i = 4'h7;
    #1;
    chk("R1 reset drive", drive_low_o, 48'h0);
    chk("R1 reset control", rdata_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2/R4: port writes and inverted readback
    pv = 48'h0123_4567_89AB;
    cyc(1, 0, 4'h0, 8'hA5, pv, 8'h00, 8'h00);
    cyc(1, 0, 4'h5, 8'h3C, pv, 8'h00, 8'h00);
    for (int p = 0; p < 6; p++) cyc(0, 1, 4'(p), 8'h00, pv, 8'h00, 8'h00);
    pv = 48'hFFFF_0000_F0F0;
    for (int p = 0; p < 6; p++) cyc(0, 1, 4'(p), 8'h00, pv, 8'h00, 8'h00);

    // R5/R3: locks on ports 0 and 2, page 1
    cyc(1, 0, 4'h7, 8'h45, pv, 8'h00, 8'h00);
    cyc(0, 1, 4'h7, 8'h00, pv, 8'h00, 8'h00);
    cyc(1, 0, 4'h0, 8'h11, pv, 8'h00, 8'h00);
    cyc(1, 0, 4'h1, 8'h22, pv, 8'h00, 8'h00);
    cyc(1, 0, 4'h2, 8'h33, pv, 8'h00, 8'h00);
    cyc(0, 0, 4'h0, 8'h00, pv, 8'h00, 8'h00);

    // R6: window on pages 1..3
    for (int a = 8; a <= 10; a++) begin
      cyc(1, 0, 4'(a), 8'(a * 7), pv, 8'h00, 8'h00);
      cyc(0, 1, 4'(a), 8'h00, pv, 8'h00, 8'(8'h90 + a));
    end
    cyc(1, 0, 4'h7, 8'h80, pv, 8'h00, 8'h00);
    cyc(1, 0, 4'h0, 8'h77, pv, 8'h00, 8'h00);
    cyc(1, 1, 4'h9, 8'h5A, pv, 8'h00, 8'hC3);
    cyc(1, 0, 4'h7, 8'hC0, pv, 8'h00, 8'h00);
    cyc(0, 1, 4'hA, 8'h00, pv, 8'h00, 8'h3E);

    // R7: page 0 closes the window
    cyc(1, 0, 4'h7, 8'h00, pv, 8'h00, 8'h00);
    for (int a = 8; a <= 10; a++) cyc(1, 1, 4'(a), 8'hFF, pv, 8'h00, 8'hEE);

    // R8/R9: pending read, ignored writes, holes
    cyc(1, 1, 4'h6, 8'hFF, pv, 8'h05, 8'h00);
    cyc(0, 1, 4'h7, 8'h00, pv, 8'h02, 8'h00);
    for (int a = 11; a <= 15; a++) cyc(1, 1, 4'(a), 8'hFF, pv, 8'h00, 8'hAA);
    cyc(0, 1, 4'h7, 8'h00, pv, 8'h00, 8'h00);

    // R10: pin changes every cycle
    for (int i = 0; i < 8; i++) cyc(0, 1, 4'(i % 6), 8'h00, {$urandom, $urandom}, 8'h00, 8'h00);

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      cyc(1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom),
          {$urandom, $urandom}, 8'($urandom), 8'($urandom));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule